// File: doc/BRIEF.md
# Page-Granular Address Range Checker

This block guards a memory port with a table of address windows. Each window has an inclusive lower bound and an exclusive upper bound, both given as 4 KiB page numbers. Each window also has its own enable bit. A configuration write port sets the bounds, the enable bits and a fill word. Every incoming read or write carries a 36-bit physical address. That address is compared in one cycle against all enabled windows.

An access that falls inside at least one enabled window is forwarded on the downstream port one cycle later. A read that falls outside every enabled window is not forwarded. It is answered with the fill word instead. A write that falls outside is dropped. Either kind of miss pulses a direction-specific error event and records the faulting address.

For a forwarded read, downstream read data must be valid in the same cycle that the downstream valid is high. The block passes that data straight to its response port.

Top module: `page_range_guard`

## Requirements
- R1: After reset every window is disabled with both bounds zero, the fill word is 0x92929292, and `dn_valid`, `rsp_valid`, `rd_err`, `wr_err` and `err_addr` are all zero.
- R2: An access sampled with `acc_valid` high that hits an enabled window appears one cycle later on `dn_valid`, with `dn_write`, `dn_addr` and `dn_wdata` equal to the sampled direction, address and data. This holds across the full 36-bit address.
- R3: A window hits when its page number `acc_addr[35:12]` satisfies lower <= page < upper. The upper bound is exclusive, and a window with lower >= upper never hits.
- R4: The enable bit of window i is bit i mod 32 of enable word i/32. A write to an enable word replaces all 32 bits of that word.
- R5: A read that misses is not forwarded. One cycle later `rsp_valid` is high and `rsp_rdata` carries the fill word.
- R6: A write that misses is dropped: `dn_valid` stays low for it.
- R7: A miss pulses `rd_err` (for a read) or `wr_err` (for a write) for exactly one cycle, one cycle after the access. In that same cycle `err_addr` takes the missing address, and it holds that value until the next miss. Both events are never high together.
- R8: The fill word can be reprogrammed. A read miss returns the fill value that was current in the cycle the read was sampled.
- R9: A configuration write in the same cycle as an access does not affect that access. It takes effect from the next cycle on.
- R10: Configuration encoding: `cfg_kind` 0 writes a lower bound and 1 writes an upper bound, with `cfg_idx` selecting the window and the page number taken from `cfg_wdata[23:0]`. Kind 2 writes enable word `cfg_idx`, and kind 3 writes the fill word. Bound writes with `cfg_idx` >= window count, and enable writes to words beyond the table, are ignored.
- R11: Every sampled read gives `rsp_valid` one cycle later. For a hit, `rsp_rdata` equals `dn_rdata`. Writes give no `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 2 | Configuration target: 0 lower, 1 upper, 2 enable word, 3 fill |
| cfg_idx | input | 8 | Window index or enable word index |
| cfg_wdata | input | 32 | Configuration write data |
| acc_valid | input | 1 | Access request valid |
| acc_write | input | 1 | Access direction, 1 for write |
| acc_addr | input | 36 | Access physical address |
| acc_wdata | input | 32 | Access write data |
| dn_valid | output | 1 | Forwarded access valid |
| dn_write | output | 1 | Forwarded access direction |
| dn_addr | output | 36 | Forwarded address |
| dn_wdata | output | 32 | Forwarded write data |
| dn_rdata | input | 32 | Downstream read data, valid with `dn_valid` |
| rsp_valid | output | 1 | Read response valid |
| rsp_rdata | output | 32 | Read response data |
| rd_err | output | 1 | Read miss event |
| wr_err | output | 1 | Write miss event |
| err_addr | output | 36 | Address of the latest miss |

## Verification
Two functions can fall in the same cycle: a table or fill update on the configuration port, and an access check that reads the same window or fill word. The bench drives both in one cycle. It disables a window while a read is issued to that window, and it reprograms the fill word while a read misses. It expects the access to be judged against the old table and fill value, and the next access against the new ones. A long pseudo-random phase mixes configuration writes and accesses cycle by cycle. Each output is compared with a behavioural model that applies every configuration write only after the access of that cycle has been judged.

// File: rtl/prg_pkg.sv
package prg_pkg;
    typedef enum logic [1:0] {
        CFG_LOWER  = 2'd0,
        CFG_UPPER  = 2'd1,
        CFG_ENABLE = 2'd2,
        CFG_FILL   = 2'd3
    } cfg_kind_e;

    localparam logic [31:0] FILL_RESET = 32'h9292_9292;
endpackage

// File: rtl/prg_win_table.sv
module prg_win_table
    import prg_pkg::*;
#(
    parameter int NUM_WIN = 16,
    parameter int PAGE_W  = 24,
    parameter int IDX_W   = 8,
    parameter int DATA_W  = 32
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            cfg_we,
    input  logic [1:0]                      cfg_kind,
    input  logic [IDX_W-1:0]                cfg_idx,
    input  logic [DATA_W-1:0]               cfg_wdata,
    output logic [NUM_WIN-1:0][PAGE_W-1:0]  lo_o,
    output logic [NUM_WIN-1:0][PAGE_W-1:0]  hi_o,
    output logic [NUM_WIN-1:0]              en_o,
    output logic [DATA_W-1:0]               fill_o
);
    localparam int WIN_IW = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;

    typedef struct packed {
        logic [NUM_WIN-1:0][PAGE_W-1:0] lo;
        logic [NUM_WIN-1:0][PAGE_W-1:0] hi;
        logic [NUM_WIN-1:0]             en;
        logic [DATA_W-1:0]              fill;
    } tbl_t;

    tbl_t tbl_d, tbl_q;
    logic idx_ok;
    logic [WIN_IW-1:0] win_sel;

    always_comb begin
        tbl_d   = tbl_q;
        idx_ok  = (int'(cfg_idx) < NUM_WIN);
        win_sel = cfg_idx[WIN_IW-1:0];
        if (cfg_we) begin
            case (cfg_kind_e'(cfg_kind))
                CFG_LOWER: if (idx_ok) tbl_d.lo[win_sel] = cfg_wdata[PAGE_W-1:0];
                CFG_UPPER: if (idx_ok) tbl_d.hi[win_sel] = cfg_wdata[PAGE_W-1:0];
                CFG_ENABLE: begin
                    for (int i = 0; i < NUM_WIN; i++) begin
                        if (int'(cfg_idx) == (i >> 5)) tbl_d.en[i] = cfg_wdata[i & 31];
                    end
                end
                default: tbl_d.fill = cfg_wdata;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_q      <= '0;
            tbl_q.fill <= FILL_RESET[DATA_W-1:0];
        end else begin
            tbl_q <= tbl_d;
        end
    end

    assign lo_o   = tbl_q.lo;
    assign hi_o   = tbl_q.hi;
    assign en_o   = tbl_q.en;
    assign fill_o = tbl_q.fill;
endmodule

// File: rtl/prg_hit_match.sv
module prg_hit_match #(
    parameter int NUM_WIN = 16,
    parameter int PAGE_W  = 24
) (
    input  logic [PAGE_W-1:0]               page,
    input  logic [NUM_WIN-1:0][PAGE_W-1:0]  lo,
    input  logic [NUM_WIN-1:0][PAGE_W-1:0]  hi,
    input  logic [NUM_WIN-1:0]              en,
    output logic                            hit
);
    logic [NUM_WIN-1:0] hit_vec;

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        assign hit_vec[g] = en[g] && (page >= lo[g]) && (page < hi[g]);
    end

    assign hit = |hit_vec;
endmodule

// File: rtl/page_range_guard.sv
module page_range_guard
    import prg_pkg::*;
#(
    parameter int NUM_WIN    = 16,
    parameter int ADDR_W     = 36,
    parameter int PAGE_SHIFT = 12,
    parameter int DATA_W     = 32,
    parameter int IDX_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_kind,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic              dn_valid,
    output logic              dn_write,
    output logic [ADDR_W-1:0] dn_addr,
    output logic [DATA_W-1:0] dn_wdata,
    input  logic [DATA_W-1:0] dn_rdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rd_err,
    output logic              wr_err,
    output logic [ADDR_W-1:0] err_addr
);
    localparam int PAGE_W = ADDR_W - PAGE_SHIFT;

    logic [NUM_WIN-1:0][PAGE_W-1:0] win_lo, win_hi;
    logic [NUM_WIN-1:0]             win_en;
    logic [DATA_W-1:0]              fill_word;
    logic                           hit;

    prg_win_table #(
        .NUM_WIN(NUM_WIN), .PAGE_W(PAGE_W), .IDX_W(IDX_W), .DATA_W(DATA_W)
    ) u_table (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_kind(cfg_kind), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
        .lo_o(win_lo), .hi_o(win_hi), .en_o(win_en), .fill_o(fill_word)
    );

    prg_hit_match #(.NUM_WIN(NUM_WIN), .PAGE_W(PAGE_W)) u_match (
        .page(acc_addr[ADDR_W-1:PAGE_SHIFT]),
        .lo(win_lo), .hi(win_hi), .en(win_en),
        .hit(hit)
    );

    typedef struct packed {
        logic              dn_valid;
        logic              dn_write;
        logic [ADDR_W-1:0] dn_addr;
        logic [DATA_W-1:0] dn_wdata;
        logic              rsp_valid;
        logic              rsp_hit;
        logic [DATA_W-1:0] rsp_fill;
        logic              rd_err;
        logic              wr_err;
        logic [ADDR_W-1:0] err_addr;
    } resp_t;

    resp_t r_d, r_q;

    always_comb begin
        r_d           = r_q;
        r_d.dn_valid  = 1'b0;
        r_d.rsp_valid = 1'b0;
        r_d.rd_err    = 1'b0;
        r_d.wr_err    = 1'b0;
        if (acc_valid) begin
            r_d.rsp_valid = !acc_write;
            r_d.rsp_hit   = hit;
            if (hit) begin
                r_d.dn_valid = 1'b1;
                r_d.dn_write = acc_write;
                r_d.dn_addr  = acc_addr;
                r_d.dn_wdata = acc_wdata;
            end else begin
                r_d.rsp_fill = fill_word;
                r_d.rd_err   = !acc_write;
                r_d.wr_err   = acc_write;
                r_d.err_addr = acc_addr;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign dn_valid  = r_q.dn_valid;
    assign dn_write  = r_q.dn_write;
    assign dn_addr   = r_q.dn_addr;
    assign dn_wdata  = r_q.dn_wdata;
    assign rsp_valid = r_q.rsp_valid;
    assign rsp_rdata = r_q.rsp_hit ? dn_rdata : r_q.rsp_fill;
    assign rd_err    = r_q.rd_err;
    assign wr_err    = r_q.wr_err;
    assign err_addr  = r_q.err_addr;
endmodule

// File: rtl/prg_checker.sv
module prg_checker #(
    parameter int ADDR_W = 36
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic              acc_write,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              dn_valid,
    input logic              rsp_valid,
    input logic              rd_err,
    input logic              wr_err,
    input logic [ADDR_W-1:0] err_addr
);
    // R7
    single_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_err && wr_err));

    // R6
    write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |-> !dn_valid && !rsp_valid);

    // R5
    read_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_err |-> rsp_valid && !dn_valid);

    // R11
    read_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && !acc_write |=> rsp_valid);

    // R2
    access_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> (dn_valid || rd_err || wr_err));

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !dn_valid && !rd_err && !wr_err && !rsp_valid);

    // R7
    err_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid ##1 (rd_err || wr_err) |-> err_addr == $past(acc_addr));
endmodule

bind page_range_guard prg_checker #(.ADDR_W(ADDR_W)) u_prg_chk (
    .clk(clk), .rst_n(rst_n),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
    .dn_valid(dn_valid), .rsp_valid(rsp_valid),
    .rd_err(rd_err), .wr_err(wr_err), .err_addr(err_addr)
);

// File: tb/page_range_guard_test.sv
module page_range_guard_test;
    localparam int NW = 16;
    localparam logic [31:0] RKEY = 32'h5A5A_0F0F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_kind = '0;
    logic [7:0]  cfg_idx = '0;
    logic [31:0] cfg_wdata = '0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [35:0] acc_addr = '0;
    logic [31:0] acc_wdata = '0;
    logic        dn_valid, dn_write, rsp_valid, rd_err, wr_err;
    logic [35:0] dn_addr, err_addr;
    logic [31:0] dn_wdata, dn_rdata, rsp_rdata;

    always #4 clk = ~clk;

    assign dn_rdata = dn_addr[31:0] ^ RKEY;

    page_range_guard uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_kind(cfg_kind), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .dn_valid(dn_valid), .dn_write(dn_write), .dn_addr(dn_addr), .dn_wdata(dn_wdata),
        .dn_rdata(dn_rdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .rd_err(rd_err), .wr_err(wr_err), .err_addr(err_addr)
    );

    int total = 0;
    int fails = 0;
    bit done = 0;

    logic [23:0] m_lo [NW];
    logic [23:0] m_hi [NW];
    logic [NW-1:0] m_en;
    logic [31:0] m_fill;
    logic [35:0] m_err;

    task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic bit m_hit(logic [35:0] a);
        for (int i = 0; i < NW; i++)
            if (m_en[i] && a[35:12] >= m_lo[i] && a[35:12] < m_hi[i]) return 1'b1;
        return 1'b0;
    endfunction

    task automatic cyc(string tag, bit cv, bit [1:0] ck, bit [7:0] ci, bit [31:0] cd,
                       bit av, bit aw, bit [35:0] aa, bit [31:0] ad);
        bit h, e_dv, e_rv, e_re, e_we;
        logic [31:0] e_rd;
        cfg_we = cv; cfg_kind = ck; cfg_idx = ci; cfg_wdata = cd;
        acc_valid = av; acc_write = aw; acc_addr = aa; acc_wdata = ad;
        h    = m_hit(aa);
        e_dv = av && h;
        e_rv = av && !aw;
        e_re = av && !aw && !h;
        e_we = av && aw && !h;
        e_rd = h ? (aa[31:0] ^ RKEY) : m_fill;
        if (av && !h) m_err = aa;
        @(posedge clk);
        if (cv) begin
            case (ck)
                2'd0: if (ci < NW) m_lo[ci] = cd[23:0];
                2'd1: if (ci < NW) m_hi[ci] = cd[23:0];
                2'd2: for (int i = 0; i < NW; i++) if (ci == i / 32) m_en[i] = cd[i % 32];
                default: m_fill = cd;
            endcase
        end
        @(negedge clk);
        check(tag, "dn_valid", 64'(dn_valid), 64'(e_dv));
        check(tag, "rsp_valid", 64'(rsp_valid), 64'(e_rv));
        check(tag, "rd_err", 64'(rd_err), 64'(e_re));
        check(tag, "wr_err", 64'(wr_err), 64'(e_we));
        check(tag, "err_addr", 64'(err_addr), 64'(m_err));
        if (e_dv) begin
            check(tag, "dn_write", 64'(dn_write), 64'(aw));
            check(tag, "dn_addr", 64'(dn_addr), 64'(aa));
            if (aw) check(tag, "dn_wdata", 64'(dn_wdata), 64'(ad));
        end
        if (e_rv) check(tag, "rsp_rdata", 64'(rsp_rdata), 64'(e_rd));
    endtask

    task automatic cfgw(string tag, bit [1:0] k, bit [7:0] i, bit [31:0] d);
        cyc(tag, 1'b1, k, i, d, 1'b0, 1'b0, '0, '0);
    endtask
    task automatic rd(string tag, bit [35:0] a);
        cyc(tag, 1'b0, '0, '0, '0, 1'b1, 1'b0, a, '0);
    endtask
    task automatic wr(string tag, bit [35:0] a, bit [31:0] d);
        cyc(tag, 1'b0, '0, '0, '0, 1'b1, 1'b1, a, d);
    endtask

    initial begin
        int cycles = 0;
        while (!done && cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed = 32'h1234_5678;
        for (int i = 0; i < NW; i++) begin m_lo[i] = '0; m_hi[i] = '0; end
        m_en = '0; m_fill = 32'h9292_9292; m_err = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: outputs quiet after reset
        check("R1", "dn_valid", 64'(dn_valid), 64'd0);
        check("R1", "rsp_valid", 64'(rsp_valid), 64'd0);
        check("R1", "rd_err", 64'(rd_err | wr_err), 64'd0);
        check("R1", "err_addr", 64'(err_addr), 64'd0);
        cyc("R1", 1'b0, '0, '0, '0, 1'b0, 1'b0, '0, '0);
        rd("R1", 36'h0_0000_1000);
        wr("R6", 36'h0_0000_0000, 32'h1111_2222);
        // R10 / R4: program window 2 and enable it
        cfgw("R10", 2'd0, 8'd2, 32'h10);
        cfgw("R10", 2'd1, 8'd2, 32'h20);
        rd("R4", 36'h0_0001_5000);
        cfgw("R4", 2'd2, 8'd0, 32'h4);
        rd("R3", 36'h0_0001_0000);
        rd("R3", 36'h0_0001_FFFC);
        rd("R3", 36'h0_0002_0000);
        rd("R3", 36'h0_0000_FFFC);
        wr("R2", 36'h0_0001_5ABC, 32'hCAFE_F00D);
        wr("R6", 36'h0_0003_0000, 32'hBAD0_BAD0);
        rd("R11", 36'h0_0001_8008);
        // R8: fill reprogram
        cfgw("R8", 2'd3, 8'd0, 32'hDEAD_BEEF);
        rd("R8", 36'h0_0004_0000);
        // R9: fill change and read miss same cycle
        cyc("R9", 1'b1, 2'd3, 8'd0, 32'h0BAD_CAFE, 1'b1, 1'b0, 36'h0_0005_0000, '0);
        rd("R9", 36'h0_0005_0000);
        // R9: disable window 2 while reading it
        cyc("R9", 1'b1, 2'd2, 8'd0, 32'h0, 1'b1, 1'b0, 36'h0_0001_2000, '0);
        rd("R9", 36'h0_0001_2000);
        cfgw("R9", 2'd2, 8'd0, 32'h4);
        // R10: out-of-range index must not alias window 2
        cfgw("R10", 2'd0, 8'd18, 32'h1F);
        rd("R10", 36'h0_0001_0000);
        cfgw("R10", 2'd0, 8'd15, 32'h40);
        cfgw("R10", 2'd1, 8'd15, 32'h50);
        cfgw("R10", 2'd2, 8'd1, 32'hFFFF_FFFF);
        rd("R10", 36'h0_0004_5000);
        // R4: window 15 is bit 15 of word 0
        cfgw("R4", 2'd2, 8'd0, 32'h0000_8004);
        rd("R4", 36'h0_0004_5000);
        // R3: empty window
        cfgw("R3", 2'd0, 8'd3, 32'h60);
        cfgw("R3", 2'd1, 8'd3, 32'h60);
        cfgw("R3", 2'd2, 8'd0, 32'h0000_800C);
        rd("R3", 36'h0_0006_0000);
        // R2: top of the 36-bit space
        cfgw("R2", 2'd0, 8'd4, 32'hF0_0000);
        cfgw("R2", 2'd1, 8'd4, 32'hF0_0010);
        cfgw("R2", 2'd2, 8'd0, 32'h0000_801C);
        wr("R2", 36'hF_0000_5004, 32'h7777_1234);
        rd("R2", 36'hF_0000_F000);
        rd("R7", 36'hF_0001_0000);
        // R7 / R11: mixed pseudo-random traffic
        for (int n = 0; n < 600; n++) begin
            bit cv, av, aw;
            bit [1:0] ck;
            bit [7:0] ci;
            bit [31:0] cd, ad;
            bit [35:0] aa;
            seed = seed * 32'd1103515245 + 32'd12345;
            cv = (seed[31:29] == 3'd0);
            ck = seed[28:27];
            ci = {5'd0, seed[26:24]} + ((ck == 2'd2) ? 8'd0 : {4'd0, seed[23], 3'd0});
            if (ck == 2'd2) ci = {7'd0, seed[22]};
            cd = (ck == 2'd3) ? seed : {25'd0, seed[22:16]};
            seed = seed * 32'd1103515245 + 32'd12345;
            av = seed[31] | seed[30];
            aw = seed[29];
            aa = {17'd0, seed[27:10], 1'b0};
            ad = seed ^ 32'h3C3C_A5A5;
            cyc("R7", cv, ck, ci, cd, av, aw, aa, ad);
        end
        cyc("R11", 1'b0, '0, '0, '0, 1'b0, 1'b0, '0, '0);
        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule